// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Port Shapes

This block is a first-in first-out buffer built on one shared storage array of 256 rows by 18 bits. The write side and the read side each have their own clock, which may be unrelated or may be the same clock. Each side picks its own word shape from a 3-bit code: 4096×1, 2048×2, 1024×4, 512×9 or 256×18. Data written at one width can therefore be read back at another width of the same family. The data buses are 18 bits wide and are aligned to bit 0.

Each port has an active-low block enable and a word enable. The sense of each word enable is a parameter. The read side can return data after one read-clock register stage or after two. Four status outputs report the fill level: full and almost-full are computed in the write domain, empty and almost-empty in the read domain. The almost thresholds are programmable. An active-low asynchronous reset empties the buffer and puts every output into a defined state. The shape codes and the read-stage select are meant to change only while reset is held.

Top module: `shape_fifo`

## Requirements
- R1: Shape code 0 selects width 1, code 1 width 2, code 2 width 4, code 3 width 9 and code 4 width 18. Data uses bits [width-1:0] of each bus. Read-data bits above the read width are driven to zero.
- R2: Words leave in the order they entered. When the two widths differ within one family (widths 1, 2 and 4, or widths 9 and 18), the earliest written bits fill the lowest read bits first.
- R3: With `rd_stage2`=0, read data is valid after the read-clock edge that performs the read. With `rd_stage2`=1, it is valid after the following read-clock edge.
- R4: `full` is high when the free space is smaller than one write word. A write attempted while `full` is high is ignored.
- R5: `empty` is high when the stored data is less than one read word. A read attempted while `empty` is high is ignored and leaves `rd_data` unchanged.
- R6: `almost_full` is high when `afull_lvl` is nonzero and the occupancy, counted in write words, is at or above it. `almost_empty` is high when the occupancy, counted in read words, is at or below `aempty_lvl`.
- R7: While `rst_n` is low, `rd_data` is 0, `full` and `almost_full` are 0, and `empty` and `almost_empty` are 1.
- R8: Shape codes 5, 6 and 7 are reserved. A port set to a reserved code performs no transfers.
- R9: While `rd_blk_n` is 1, no read occurs and `rd_data` holds its value. While `wr_blk_n` is 1, no write occurs.
- R10: With the default parameters, `wr_en` is active low and `rd_en` is active high. Parameters `WR_EN_HIGH` and `RD_EN_HIGH` select the active level of each.
- R11: A write becomes visible on `empty` after two edges of the read clock following the write edge. A read becomes visible on `full` after two edges of the write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_shape | input | 3 | Write word shape code |
| rd_shape | input | 3 | Read word shape code |
| wr_blk_n | input | 1 | Write port block enable, active low |
| rd_blk_n | input | 1 | Read port block enable, active low |
| wr_en | input | 1 | Write enable, polarity set by parameter |
| rd_en | input | 1 | Read enable, polarity set by parameter |
| rd_stage2 | input | 1 | 1 adds a second output register stage |
| wr_data | input | 18 | Write data, low bits used |
| afull_lvl | input | 13 | Almost-full threshold in write words |
| aempty_lvl | input | 13 | Almost-empty threshold in read words |
| rd_data | output | 18 | Read data, low bits valid |
| full | output | 1 | No room for a write word |
| almost_full | output | 1 | Occupancy at or above the write threshold |
| empty | output | 1 | Less than one read word stored |
| almost_empty | output | 1 | Occupancy at or below the read threshold |

## Verification
A write and a read can fall on the same clock edge. This matters most when the buffer is one word from full or holds exactly one word, because then each side acts on its own delayed view of the other pointer. The bench drives both clocks from one source and runs long stretches of simultaneous writes and reads, as well as fills to full and drains to empty. It judges each edge against a bit-level queue model that carries the two-edge crossing delay of each pointer. The model predicts on every cycle which transfer fires and what each flag and the output word must be.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int DATA_W        = 18;
    localparam int SLOT_LOG2     = 12;
    localparam int SLOTS         = 1 << SLOT_LOG2;
    localparam int PTR_W         = SLOT_LOG2 + 1;
    localparam int ROW_SLOT_LOG2 = 4;
    localparam int ROWS          = SLOTS >> ROW_SLOT_LOG2;
    localparam int ROW_W         = SLOT_LOG2 - ROW_SLOT_LOG2;
    localparam int COL_W         = 5;

    typedef struct packed {
        logic              ok;
        logic              nine;
        logic [2:0]        sh;
        logic [DATA_W-1:0] mask;
    } shape_t;

    function automatic shape_t decode_shape(input logic [2:0] code);
        shape_t s;
        s = '0;
        case (code)
            3'd0: begin s.ok = 1'b1; s.sh = 3'd0; s.mask = DATA_W'(18'h00001); end
            3'd1: begin s.ok = 1'b1; s.sh = 3'd1; s.mask = DATA_W'(18'h00003); end
            3'd2: begin s.ok = 1'b1; s.sh = 3'd2; s.mask = DATA_W'(18'h0000F); end
            3'd3: begin s.ok = 1'b1; s.nine = 1'b1; s.sh = 3'd3; s.mask = DATA_W'(18'h001FF); end
            3'd4: begin s.ok = 1'b1; s.nine = 1'b1; s.sh = 3'd4; s.mask = DATA_W'(18'h3FFFF); end
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic [PTR_W-1:0] bin2gray(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_W-1:0] gray2bin(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic logic [COL_W-1:0] slot_col(input logic nine,
                                                  input logic [ROW_SLOT_LOG2-1:0] low);
        if (nine) return low[ROW_SLOT_LOG2-1] ? COL_W'(9) : COL_W'(0);
        return COL_W'(low);
    endfunction
endpackage

// File: rtl/sfifo_sync.sv
module sfifo_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.chain[STAGES-1];
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store
    import sfifo_pkg::*;
(
    input  logic              wr_clk,
    input  logic              we,
    input  logic [SLOT_LOG2-1:0] waddr,
    input  logic              wnine,
    input  logic [DATA_W-1:0] wmask,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SLOT_LOG2-1:0] raddr,
    input  logic              rnine,
    input  logic [DATA_W-1:0] rmask,
    output logic [DATA_W-1:0] rword
);
    logic [DATA_W-1:0] mem [ROWS];

    logic [ROW_W-1:0]  wrow, rrow;
    logic [COL_W-1:0]  wcol, rcol;
    logic [DATA_W-1:0] bit_sel, bit_val;

    always_comb begin
        wrow    = waddr[SLOT_LOG2-1:ROW_SLOT_LOG2];
        rrow    = raddr[SLOT_LOG2-1:ROW_SLOT_LOG2];
        wcol    = slot_col(wnine, waddr[ROW_SLOT_LOG2-1:0]);
        rcol    = slot_col(rnine, raddr[ROW_SLOT_LOG2-1:0]);
        bit_sel = wmask << wcol;
        bit_val = (wdata & wmask) << wcol;
        rword   = (mem[rrow] >> rcol) & rmask;
    end

    always_ff @(posedge wr_clk) begin
        if (we) mem[wrow] <= (mem[wrow] & ~bit_sel) | bit_val;
    end
endmodule

// File: rtl/sfifo_wport.sv
module sfifo_wport
    import sfifo_pkg::*;
#(
    parameter bit EN_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       shape,
    input  logic [2:0]       peer_shape,
    input  logic             blk_n,
    input  logic             en,
    input  logic [PTR_W-1:0] peer_gray,
    input  logic [PTR_W-1:0] lvl,
    output logic             fire,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] gray,
    output logic             full,
    output logic             afull
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] gray;
    } wst_t;

    wst_t   s_d, s_q;
    shape_t own, peer;
    logic [PTR_W-1:0] peer_bin, occ, occ_words, step;

    always_comb begin
        own       = decode_shape(shape);
        peer      = decode_shape(peer_shape);
        peer_bin  = gray2bin(peer_gray) << peer.sh;
        step      = PTR_W'(1) << own.sh;
        occ       = s_q.ptr - peer_bin;
        occ_words = occ >> own.sh;
        full      = own.ok && (({1'b0, occ} + {1'b0, step}) > (PTR_W+1)'(SLOTS));
        afull     = (lvl != '0) && (occ_words >= lvl);
        fire      = own.ok && !blk_n && (en == EN_HIGH) && !full;
        s_d       = s_q;
        if (fire) s_d.ptr = s_q.ptr + step;
        s_d.gray  = bin2gray(s_d.ptr >> own.sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr  = s_q.ptr;
    assign gray = s_q.gray;
endmodule

// File: rtl/sfifo_rport.sv
module sfifo_rport
    import sfifo_pkg::*;
#(
    parameter bit EN_HIGH = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        shape,
    input  logic [2:0]        peer_shape,
    input  logic              blk_n,
    input  logic              en,
    input  logic              stage2,
    input  logic [PTR_W-1:0]  peer_gray,
    input  logic [PTR_W-1:0]  lvl,
    input  logic [DATA_W-1:0] rword,
    output logic [PTR_W-1:0]  ptr,
    output logic [PTR_W-1:0]  gray,
    output logic              nine,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] data,
    output logic              empty,
    output logic              aempty
);
    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [PTR_W-1:0]  gray;
        logic [DATA_W-1:0] out1;
        logic [DATA_W-1:0] out2;
    } rst_t;

    rst_t   s_d, s_q;
    shape_t own, peer;
    logic [PTR_W-1:0] peer_bin, occ, occ_words, step;
    logic             fire;

    always_comb begin
        own       = decode_shape(shape);
        peer      = decode_shape(peer_shape);
        peer_bin  = gray2bin(peer_gray) << peer.sh;
        step      = PTR_W'(1) << own.sh;
        occ       = peer_bin - s_q.ptr;
        occ_words = occ >> own.sh;
        empty     = occ < step;
        aempty    = occ_words <= lvl;
        fire      = own.ok && !blk_n && (en == EN_HIGH) && !empty;
        s_d       = s_q;
        if (!blk_n) s_d.out2 = s_q.out1;
        if (fire) begin
            s_d.ptr  = s_q.ptr + step;
            s_d.out1 = rword;
        end
        s_d.gray  = bin2gray(s_d.ptr >> own.sh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr  = s_q.ptr;
    assign gray = s_q.gray;
    assign nine = own.nine;
    assign mask = own.mask;
    assign data = stage2 ? s_q.out2 : s_q.out1;
endmodule

// File: rtl/shape_fifo.sv
module shape_fifo
    import sfifo_pkg::*;
#(
    parameter bit WR_EN_HIGH = 1'b0,
    parameter bit RD_EN_HIGH = 1'b1,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [2:0]        wr_shape,
    input  logic [2:0]        rd_shape,
    input  logic              wr_blk_n,
    input  logic              rd_blk_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              rd_stage2,
    input  logic [17:0]       wr_data,
    input  logic [12:0]       afull_lvl,
    input  logic [12:0]       aempty_lvl,
    output logic [17:0]       rd_data,
    output logic              full,
    output logic              almost_full,
    output logic              empty,
    output logic              almost_empty
);
    logic [PTR_W-1:0]  wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    logic [PTR_W-1:0]  wgray_at_rd, rgray_at_wr;
    logic              wfire, rnine;
    logic [DATA_W-1:0] rmask, rword;
    shape_t            wdec;

    assign wdec = decode_shape(wr_shape);

    sfifo_sync #(.W(PTR_W), .STAGES(SYNC_DEPTH)) u_sync_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rptr_gray), .q(rgray_at_wr)
    );

    sfifo_sync #(.W(PTR_W), .STAGES(SYNC_DEPTH)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wptr_gray), .q(wgray_at_rd)
    );

    sfifo_wport #(.EN_HIGH(WR_EN_HIGH)) u_wport (
        .clk(wr_clk), .rst_n(rst_n), .shape(wr_shape), .peer_shape(rd_shape),
        .blk_n(wr_blk_n), .en(wr_en), .peer_gray(rgray_at_wr), .lvl(afull_lvl),
        .fire(wfire), .ptr(wptr_bin), .gray(wptr_gray),
        .full(full), .afull(almost_full)
    );

    sfifo_rport #(.EN_HIGH(RD_EN_HIGH)) u_rport (
        .clk(rd_clk), .rst_n(rst_n), .shape(rd_shape), .peer_shape(wr_shape),
        .blk_n(rd_blk_n), .en(rd_en), .stage2(rd_stage2),
        .peer_gray(wgray_at_rd), .lvl(aempty_lvl), .rword(rword),
        .ptr(rptr_bin), .gray(rptr_gray), .nine(rnine), .mask(rmask),
        .data(rd_data), .empty(empty), .aempty(almost_empty)
    );

    sfifo_store u_store (
        .wr_clk(wr_clk), .we(wfire), .waddr(wptr_bin[SLOT_LOG2-1:0]),
        .wnine(wdec.nine), .wmask(wdec.mask), .wdata(wr_data),
        .raddr(rptr_bin[SLOT_LOG2-1:0]), .rnine(rnine), .rmask(rmask),
        .rword(rword)
    );
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        rst_n,
    input logic [2:0]  wr_shape,
    input logic        rd_blk_n,
    input logic        rd_stage2,
    input logic [17:0] rd_data,
    input logic        full,
    input logic        almost_full,
    input logic        empty,
    input logic        almost_empty,
    input logic [12:0] wptr,
    input logic [12:0] rptr
);
    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |=> $stable(wptr));

    assert_no_underflow_R5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |=> $stable(rptr));

    assert_block_hold_R9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_blk_n |=> ($stable(rd_data) || !$stable(rd_stage2)));

    assert_aempty_covers_empty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);

    assert_reserved_write_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_shape > 3'd4) |=> $stable(wptr));

    always @(posedge wr_clk) begin
        if (!rst_n) begin
            assert_reset_wflags_R7: assert (!full && !almost_full);
        end
    end

    always @(posedge rd_clk) begin
        if (!rst_n) begin
            assert_reset_rside_R7: assert (empty && almost_empty && rd_data == 18'd0);
        end
    end
endmodule

bind shape_fifo sfifo_chk u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_shape(wr_shape),
    .rd_blk_n(rd_blk_n), .rd_stage2(rd_stage2), .rd_data(rd_data),
    .full(full), .almost_full(almost_full), .empty(empty),
    .almost_empty(almost_empty), .wptr(wptr_bin), .rptr(rptr_bin)
);

// File: tb/test_shape_fifo.sv
`timescale 1ns/1ps
module test_shape_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  wr_shape = 3'd4, rd_shape = 3'd4;
    logic        wr_blk_n = 1'b1, rd_blk_n = 1'b1, wr_en = 1'b1, rd_en = 1'b0;
    logic        rd_stage2 = 1'b0;
    logic [17:0] wr_data = '0;
    logic [12:0] afull_lvl = 13'd0, aempty_lvl = 13'd0;
    logic [17:0] rd_data;
    logic        full, almost_full, empty, almost_empty;

    always #2.5 clk = ~clk;

    shape_fifo i_shape_fifo (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_shape(wr_shape), .rd_shape(rd_shape),
        .wr_blk_n(wr_blk_n), .rd_blk_n(rd_blk_n), .wr_en(wr_en), .rd_en(rd_en),
        .rd_stage2(rd_stage2), .wr_data(wr_data), .afull_lvl(afull_lvl),
        .aempty_lvl(aempty_lvl), .rd_data(rd_data), .full(full),
        .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty)
    );

    int checks = 0, errors = 0;
    bit live = 0, done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int wid(input logic [2:0] c);
        case (c)
            3'd0: return 1;  3'd1: return 2;  3'd2: return 4;
            3'd3: return 9;  3'd4: return 18; default: return 0;
        endcase
    endfunction

    function automatic int shf(input logic [2:0] c);
        return (c < 3'd5) ? int'(c) : 0;
    endfunction

    // behavioural reference: bit queue plus slot counters with two-edge crossing delay
    bit q[$];
    int wcnt = 0, rcnt = 0, wq1 = 0, wq2 = 0, rq1 = 0, rq2 = 0;
    logic [17:0] m1 = '0, m2 = '0;

    function automatic bit m_full();
        return (wr_shape < 3'd5) && ((wcnt - rq2) > 4096 - (1 << shf(wr_shape)));
    endfunction
    function automatic bit m_empty();
        return (wq2 - rcnt) < (1 << shf(rd_shape));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            wcnt = 0; rcnt = 0; wq1 = 0; wq2 = 0; rq1 = 0; rq2 = 0; m1 = '0; m2 = '0;
        end else begin
            bit fw, fr;
            logic [17:0] word;
            fw = (wr_shape < 3'd5) && !wr_blk_n && !wr_en && !m_full();
            fr = (rd_shape < 3'd5) && !rd_blk_n && rd_en && !m_empty();
            rq2 = rq1; rq1 = rcnt; wq2 = wq1; wq1 = wcnt;
            if (fw) begin
                for (int i = 0; i < wid(wr_shape); i++) q.push_back(wr_data[i]);
                wcnt += 1 << shf(wr_shape);
            end
            if (!rd_blk_n) m2 = m1;
            if (fr) begin
                word = '0;
                for (int i = 0; i < wid(rd_shape); i++) word[i] = q.pop_front();
                m1 = word;
                rcnt += 1 << shf(rd_shape);
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            logic [17:0] rm;
            rm = 18'((1 << wid(rd_shape)) - 1);
            chk("R4 full", full, m_full());
            chk("R5 empty", empty, m_empty());
            chk("R6 almost_full", almost_full,
                (afull_lvl != 0) && (((wcnt - rq2) >> shf(wr_shape)) >= afull_lvl));
            chk("R6 almost_empty", almost_empty,
                ((wq2 - rcnt) >> shf(rd_shape)) <= aempty_lvl);
            chk("R2 rd_data", rd_data & rm, rd_stage2 ? m2 : m1);
            chk("R1 upper bits zero", rd_data & ~rm, 0);
        end
    end

    task automatic drive(input logic wb, input logic we, input logic [17:0] wd,
                         input logic rb, input logic re);
        wr_blk_n = wb; wr_en = we; wr_data = wd; rd_blk_n = rb; rd_en = re;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, '0, 1'b1, 1'b0);
    endtask

    task automatic do_reset(input logic [2:0] ws, input logic [2:0] rs, input logic p);
        rst_n = 1'b0; wr_shape = ws; rd_shape = rs; rd_stage2 = p;
        idle();
        chk("R7 reset rd_data", rd_data, 0);
        chk("R7 reset full", full, 0);
        chk("R7 reset almost_full", almost_full, 0);
        chk("R7 reset empty", empty, 1);
        chk("R7 reset almost_empty", almost_empty, 1);
        rst_n = 1'b1;
        idle();
    endtask

    function automatic logic [17:0] pat(input int i, input logic [2:0] c);
        return 18'((i * 40503 + 12345) & ((1 << wid(c)) - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        afull_lvl = 13'd5; aempty_lvl = 13'd2;
        live = 1;
        do_reset(3'd4, 3'd4, 1'b0);

        // R11: crossing latency of a single write into an empty buffer
        drive(1'b0, 1'b0, 18'h2A5C3, 1'b1, 1'b0);
        chk("R11 empty after write edge", empty, 1);
        idle();
        chk("R11 empty one edge later", empty, 1);
        idle();
        chk("R11 empty two edges later", empty, 0);
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R3 same-stage data", rd_data, 18'h2A5C3);

        // R10: inactive enable levels move nothing
        drive(1'b0, 1'b1, 18'h11111, 1'b0, 1'b0);
        repeat (3) idle();
        chk("R10 wr_en high ignored", empty, 1);

        // R9: read with block enable high holds
        drive(1'b0, 1'b0, 18'h0BEEF, 1'b1, 1'b0);
        repeat (2) idle();
        drive(1'b1, 1'b1, '0, 1'b1, 1'b1);
        chk("R9 data held", rd_data, 18'h2A5C3);
        chk("R9 word kept", empty, 0);
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R9 later read", rd_data, 18'h0BEEF);
        // R5: read on empty ignored
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R5 read on empty", rd_data, 18'h0BEEF);

        // simultaneous streaming at 18 bits
        for (int i = 0; i < 300; i++) drive(1'b0, 1'b0, pat(i, 3'd4), 1'b0, 1'b1);
        repeat (6) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);

        // R3: two-stage output
        do_reset(3'd4, 3'd4, 1'b1);
        drive(1'b0, 1'b0, 18'h1357A, 1'b1, 1'b0);
        repeat (2) idle();
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R3 second stage not yet", rd_data, 0);
        drive(1'b1, 1'b1, '0, 1'b0, 1'b0);
        chk("R3 second stage", rd_data, 18'h1357A);
        for (int i = 0; i < 100; i++) drive(1'b0, 1'b0, pat(i, 3'd4), 1'b0, i[0]);
        repeat (60) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);

        // R4: fill 4-bit buffer, overflow attempts, drain
        afull_lvl = 13'd1000; aempty_lvl = 13'd3;
        do_reset(3'd2, 3'd2, 1'b0);
        for (int i = 0; i < 1024; i++) drive(1'b0, 1'b0, pat(i, 3'd2), 1'b1, 1'b0);
        chk("R4 full after 1024 words", full, 1);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, 18'hF, 1'b1, 1'b0);
        for (int i = 0; i < 1030; i++) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R5 drained", empty, 1);
        chk("R6 almost_empty drained", almost_empty, 1);

        // R2: mixed widths within a family
        afull_lvl = 13'd6; aempty_lvl = 13'd1;
        do_reset(3'd2, 3'd0, 1'b0);
        for (int i = 0; i < 8; i++) drive(1'b0, 1'b0, pat(i, 3'd2), 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        do_reset(3'd0, 3'd1, 1'b0);
        for (int i = 0; i < 30; i++) drive(1'b0, 1'b0, pat(i, 3'd0), 1'b0, 1'b1);
        repeat (10) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        do_reset(3'd3, 3'd4, 1'b0);
        drive(1'b0, 1'b0, 18'h0012F, 1'b1, 1'b0);
        drive(1'b0, 1'b0, 18'h001A4, 1'b1, 1'b0);
        repeat (2) idle();
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R2 nine into eighteen", rd_data, {9'h1A4, 9'h12F});
        for (int i = 0; i < 50; i++) drive(1'b0, 1'b0, pat(i, 3'd3), 1'b0, 1'b1);
        repeat (30) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        do_reset(3'd4, 3'd3, 1'b0);
        drive(1'b0, 1'b0, {9'h0C3, 9'h155}, 1'b1, 1'b0);
        repeat (2) idle();
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R2 eighteen low half first", rd_data, 18'h155);
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R2 eighteen high half second", rd_data, 18'h0C3);

        // R1: unused write bits do not reach the read side
        do_reset(3'd2, 3'd2, 1'b0);
        drive(1'b0, 1'b0, 18'h3FFF5, 1'b1, 1'b0);
        repeat (2) idle();
        drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R1 width 4 read", rd_data, 18'h5);

        // R8: reserved shape codes
        do_reset(3'd5, 3'd4, 1'b0);
        repeat (3) drive(1'b0, 1'b0, 18'h3, 1'b1, 1'b0);
        repeat (3) idle();
        chk("R8 reserved write code", empty, 1);
        do_reset(3'd4, 3'd7, 1'b0);
        drive(1'b0, 1'b0, 18'h3, 1'b1, 1'b0);
        repeat (4) drive(1'b1, 1'b1, '0, 1'b0, 1'b1);
        chk("R8 reserved read code", rd_data, 0);

        // R7: reset in the middle of traffic
        do_reset(3'd4, 3'd4, 1'b0);
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, pat(i, 3'd4), 1'b1, 1'b0);
        do_reset(3'd4, 3'd4, 1'b0);
        chk("R7 empty after mid reset", empty, 1);

        done = 1;
        live = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule